// File: doc/BRIEF.md
# Lane-Parallel Multi-Limb Carry Adder

This block adds several independent big integers side by side, one limb position per cycle. Each input vector carries, for every lane, the limb of that lane's own integer at the current position. The limbs arrive from least to most significant. Each lane adds its A limb, its B limb and the carry left over from the previous position. The result is returned as a wrapped payload, and the carry is kept for the same lane of the next vector.

Limbs are stored in words wider than their payload. When the payload is narrower than the word, the sum fits in the word and the carry is bit PAY_W of the lane sum. When the payload fills the word, the carry is recovered from the top bits of the operands and the sum.

A start marker on the first limb of an operation clears every lane carry. A last marker on the final limb exposes any remaining carry per lane as an overflow. A flag reports whether any lane carried out of the current limb. Both the input and the output use a valid/ready handshake.

Top module: `mlimb_adder`

## Requirements
- R1: Each lane's output payload equals (A payload + B payload + lane carry-in) modulo 2^PAY_W, independently of the other lanes. Lane l occupies bits [l*LIMB_W +: LIMB_W].
- R2: Output bits above the payload in every lane (bits 63:62 by default) are always zero while out_valid is high.
- R3: A lane's carry is bit PAY_W of its lane sum. That carry is added into the same lane of the next accepted limb vector.
- R4: When a vector is accepted with in_first high, all lane carries are treated as zero for that limb.
- R5: out_any_carry is high exactly when at least one lane produced a carry out of the limb shown on the outputs.
- R6: On a limb accepted with in_last high, out_overflow bit l equals lane l's carry out. On any other limb, out_overflow is all zero.
- R7: in_ready = !out_valid || out_ready. While out_valid is high and out_ready is low, the outputs and lane carries hold unchanged.
- R8: Input bits above the payload in each lane are ignored.
- R9: An accepted vector's result appears on the outputs with out_valid high at the next clock edge, and results leave in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input vector valid |
| in_ready | output | 1 | Block can accept a vector |
| in_first | input | 1 | Vector is the least significant limb of an operation |
| in_last | input | 1 | Vector is the most significant limb of an operation |
| in_a | input | LANES*LIMB_W | A limbs, one per lane |
| in_b | input | LANES*LIMB_W | B limbs, one per lane |
| out_valid | output | 1 | Result vector valid |
| out_ready | input | 1 | Downstream takes the result |
| out_limbs | output | LANES*LIMB_W | Wrapped payload sums, top bits zero |
| out_any_carry | output | 1 | OR of the lane carries out of this limb |
| out_overflow | output | LANES | Per-lane carry out of the last limb |
| out_last | output | 1 | Result belongs to the last limb |

## Verification
The bench uses the default parameters: four lanes, 64-bit words and a 62-bit payload. With these values the narrow-payload path is exercised, so carries land in bit 62 and the two spare input bits can carry junk that must be dropped. Ten-limb operations per lane are compared against a single wide addition. These include all-ones payloads that ripple a carry through every limb, and a back-to-back operation that must not inherit the final carry. The output side is throttled at random, so stalls land mid-chain.

// File: rtl/mlimb_adder.sv
module mlimb_adder #(
  parameter int LANES  = 4,
  parameter int LIMB_W = 64,
  parameter int PAY_W  = 62
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic                      in_first,
  input  logic                      in_last,
  input  logic [LANES*LIMB_W-1:0]   in_a,
  input  logic [LANES*LIMB_W-1:0]   in_b,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [LANES*LIMB_W-1:0]   out_limbs,
  output logic                      out_any_carry,
  output logic [LANES-1:0]          out_overflow,
  output logic                      out_last
);
  localparam int VEC_W = LANES * LIMB_W;

  logic [LANES-1:0] carry_q, carry_d, cin;
  logic [VEC_W-1:0] sum_d;
  logic             accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign cin      = in_first ? '0 : carry_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (PAY_W < LIMB_W) begin : g_narrow
      logic [PAY_W:0] s;
      wire lane_unused = ^{in_a[l*LIMB_W+PAY_W +: LIMB_W-PAY_W],
                           in_b[l*LIMB_W+PAY_W +: LIMB_W-PAY_W]};
      assign s = {1'b0, in_a[l*LIMB_W +: PAY_W]} + {1'b0, in_b[l*LIMB_W +: PAY_W]}
               + {{PAY_W{1'b0}}, cin[l]};
      assign carry_d[l] = s[PAY_W];
      assign sum_d[l*LIMB_W +: LIMB_W] = {{(LIMB_W-PAY_W){1'b0}}, s[PAY_W-1:0]};
    end else begin : g_full
      logic [LIMB_W-1:0] a, b, s, c;
      assign a = in_a[l*LIMB_W +: LIMB_W];
      assign b = in_b[l*LIMB_W +: LIMB_W];
      assign s = a + b + {{(LIMB_W-1){1'b0}}, cin[l]};
      assign c = (a & b) | ((a ^ b) & ~s);
      assign carry_d[l] = c[LIMB_W-1];
      assign sum_d[l*LIMB_W +: LIMB_W] = s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_limbs     <= '0;
      out_any_carry <= 1'b0;
      out_overflow  <= '0;
      out_last      <= 1'b0;
      carry_q       <= '0;
    end else if (accept) begin
      out_valid     <= 1'b1;
      out_limbs     <= sum_d;
      out_any_carry <= |carry_d;
      out_overflow  <= in_last ? carry_d : '0;
      out_last      <= in_last;
      carry_q       <= carry_d;
    end else if (out_ready) begin
      out_valid     <= 1'b0;
    end
  end
endmodule

// File: rtl/mlimb_adder_chk.sv
module mlimb_adder_chk #(
  parameter int LANES  = 4,
  parameter int LIMB_W = 64,
  parameter int PAY_W  = 62
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [LANES*LIMB_W-1:0] out_limbs,
  input logic                    out_any_carry,
  input logic [LANES-1:0]        out_overflow,
  input logic                    out_last
);
  function automatic logic [LANES*LIMB_W-1:0] hi_mask();
    logic [LANES*LIMB_W-1:0] m = '0;
    for (int l = 0; l < LANES; l++)
      for (int b = PAY_W; b < LIMB_W; b++) m[l*LIMB_W+b] = 1'b1;
    return m;
  endfunction
  localparam logic [LANES*LIMB_W-1:0] HI_MASK = hi_mask();

  p_hi_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_limbs & HI_MASK) == '0);
  p_any_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> ((|out_overflow) == out_any_carry));
  p_ovf_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> out_overflow == '0);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_limbs)
      && $stable(out_overflow) && $stable(out_any_carry) && $stable(out_last)));
  p_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

bind mlimb_adder mlimb_adder_chk #(.LANES(LANES), .LIMB_W(LIMB_W), .PAY_W(PAY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_limbs(out_limbs),
  .out_any_carry(out_any_carry), .out_overflow(out_overflow), .out_last(out_last));

// File: tb/mlimb_adder_bench.sv
module mlimb_adder_bench;
  localparam int LANES = 4, LIMB_W = 64, PAY_W = 62, NL = 10;
  localparam int VEC_W = LANES * LIMB_W;
  localparam int WW = NL * PAY_W + 2;

  typedef struct packed {
    logic [VEC_W-1:0] limbs;
    logic             any;
    logic [LANES-1:0] ovf;
    logic             last;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_first = 0, in_last = 0, out_ready = 0;
  logic [VEC_W-1:0] in_a = '0, in_b = '0;
  logic in_ready, out_valid, out_any_carry, out_last;
  logic [VEC_W-1:0] out_limbs;
  logic [LANES-1:0] out_overflow;

  int checks = 0, errors = 0;
  bit done = 0;
  exp_t q[$];
  logic [WW-1:0] opa [LANES];
  logic [WW-1:0] opb [LANES];

  always #10 clk = ~clk;

  mlimb_adder u_mlimb_adder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .in_last(in_last), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_limbs(out_limbs),
    .out_any_carry(out_any_carry), .out_overflow(out_overflow), .out_last(out_last));

  task automatic chk(input bit ok, input string req, input logic [VEC_W-1:0] act,
                     input logic [VEC_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [61:0] rnd62();
    return {$urandom, $urandom};
  endfunction

  // Sends one NL-limb operation from opa/opb; junk fills the spare input bits (R8).
  task automatic run_op(input bit junk);
    for (int k = 0; k < NL; k++) begin
      exp_t e;
      logic [LANES-1:0] cy;
      bit go;
      for (int l = 0; l < LANES; l++) begin
        logic [WW-1:0] m, sp;
        m  = (WW'(1) << (PAY_W*(k+1))) - 1;
        sp = (opa[l] & m) + (opb[l] & m);
        cy[l] = sp[PAY_W*(k+1)];
        e.limbs[l*LIMB_W +: LIMB_W] = {2'b00, sp[PAY_W*k +: PAY_W]};
        in_a[l*LIMB_W +: LIMB_W] = {junk ? 2'($urandom) : 2'b00, opa[l][PAY_W*k +: PAY_W]};
        in_b[l*LIMB_W +: LIMB_W] = {junk ? 2'($urandom) : 2'b00, opb[l][PAY_W*k +: PAY_W]};
      end
      e.any  = |cy;
      e.ovf  = (k == NL-1) ? cy : '0;
      e.last = (k == NL-1);
      in_first = (k == 0);
      in_last  = (k == NL-1);
      in_valid = 1;
      q.push_back(e);
      go = 0;
      while (!go) begin
        #5 go = in_ready;
        @(negedge clk);
      end
      in_valid = 0;
    end
  endtask

  // Monitor / scoreboard
  logic pv = 0, pr = 0;
  exp_t prev;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (pv && !pr) begin
          chk(out_valid && out_limbs == prev.limbs && out_overflow == prev.ovf
              && out_any_carry == prev.any, "R7 stall hold",
              {out_overflow, out_limbs[VEC_W-LANES-1:0]},
              {prev.ovf, prev.limbs[VEC_W-LANES-1:0]});
        end
        out_ready = ($urandom % 4) != 0;
        #2;
        if (out_valid) chk(in_ready == out_ready, "R7 in_ready", VEC_W'(in_ready), VEC_W'(out_ready));
        if (out_valid && out_ready) begin
          exp_t e;
          if (q.size() == 0) chk(0, "R9 unexpected result", VEC_W'(1), VEC_W'(0));
          else begin
            e = q.pop_front();
            chk(out_limbs == e.limbs, "R1/R3/R8 limbs", out_limbs, e.limbs);
            chk(out_any_carry == e.any, "R5 any carry", VEC_W'(out_any_carry), VEC_W'(e.any));
            chk(out_overflow == e.ovf, "R6 overflow", VEC_W'(out_overflow), VEC_W'(e.ovf));
            chk(out_last == e.last, "R6 last marker", VEC_W'(out_last), VEC_W'(e.last));
          end
        end
        pv = out_valid; pr = out_ready;
        prev = '{out_limbs, out_any_carry, out_overflow, out_last};
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(!out_valid && in_ready, "R7 reset state", VEC_W'({out_valid, in_ready}), VEC_W'(2'b01));
    @(negedge clk);
    // R1 R3: random operations
    for (int t = 0; t < 6; t++) begin
      for (int l = 0; l < LANES; l++) begin
        opa[l] = '0; opb[l] = '0;
        for (int k = 0; k < NL; k++) begin
          opa[l][PAY_W*k +: PAY_W] = rnd62();
          opb[l][PAY_W*k +: PAY_W] = rnd62();
        end
      end
      run_op(t >= 3);
    end
    // R3 R6: all-ones ripple in lanes 0 and 2, none in others
    for (int l = 0; l < LANES; l++) begin
      opa[l] = '0; opb[l] = '0;
      for (int k = 0; k < NL; k++) opa[l][PAY_W*k +: PAY_W] = '1;
      if (l % 2 == 0) opb[l][0] = 1'b1;
    end
    run_op(1);
    // R4: small operation right after carry-out; carry must not leak in
    for (int l = 0; l < LANES; l++) begin
      opa[l] = WW'(l + 1); opb[l] = WW'(5);
    end
    run_op(0);
    // R6: max payloads everywhere, overflow on every lane
    for (int l = 0; l < LANES; l++) begin
      opa[l] = '0; opb[l] = '0;
      for (int k = 0; k < NL; k++) begin
        opa[l][PAY_W*k +: PAY_W] = '1; opb[l][PAY_W*k +: PAY_W] = '1;
      end
    end
    run_op(1);
    repeat (50) @(negedge clk);
    chk(q.size() == 0, "R9 all results delivered", VEC_W'(q.size()), VEC_W'(0));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule